// File: doc/BRIEF.md
# Grouped Event Selection Matrix

This block sits between a large set of raw hardware event lines and a bank of event counters. The event lines form a two-dimensional array: eight groups (columns) of 256 codes (rows) each. A single shared row-select register chooses one code in every group at the same time. Each counter then names only a group through its own type register, so it follows whichever code that group currently has selected. Two counters that name the same group always see the same event. Two different codes of one group can never be counted at once.

Every group also carries attributes for its current event: the index of the originating processor, a flag that marks the event as independent of any processor ID, and a subunit index. A per-counter filter register accepts or rejects the event based on these attributes. A reserved type value turns a counter into a cycle counter that pulses on every clock, outside the group and code scheme. Configuration is written and read through a simple synchronous register port. The block drives one registered pulse per counter into the counter bank.

Top module: `evsel_matrix`

## Requirements
- R1: After a synchronous active-low reset, every counter pulse is 0 and every mapped register reads as zero.
- R2: The row-select register at address 0x410 stores and reads back all 64 written bits. Group g's code is bits [8g+7:8g], bit 63 is the global enable, and a write to any other address leaves it unchanged.
- R3: Counter n's type register sits at 0x500+2n and reads back 8 bits. Its filter register sits at 0x501+2n and keeps only bits [19:17] and [2:0]; every other bit reads as 0.
- R4: A counter whose type is a group g in 0..7 pulses exactly one clock after event input evt_src[g*256 + code_g] is high, provided the enable is set and the filter accepts. code_g is the group's field in the row-select register. Other codes of that group produce no pulse.
- R5: While bit 63 of the row-select register is 0, no counter with a group type pulses.
- R6: Counters with the same group type produce identical pulses.
- R7: A type value from 8 to 0xFD, or 0xFF, never produces a pulse.
- R8: Type 0xFE makes the counter pulse every clock, regardless of the enable, the filter and the event inputs.
- R9: The event's subunit index s (0..2, from grp_sub[2g+1:2g]) is accepted only when filter bit 17+s is set. Subunit index 3 is never accepted.
- R10: If the group's grp_indep bit is 1, the event is accepted only when filter bit 2 is set. Otherwise, filter bit c must be set, where c is the originating processor index on grp_cpu[g] (0 or 1). Both this check and the subunit check must pass.
- R11: Writes to unmapped addresses change no register, and reads of unmapped addresses return zero.
- R12: Group 7's code field includes bit 63, so while the enable is set, group 7 can only select codes 0x80 to 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 12 | Configuration register address |
| cfg_wdata | input | 64 | Configuration write data |
| cfg_rdata | output | 64 | Configuration read data (combinational from address) |
| evt_src | input | 2048 | Raw event lines, index group*256+code |
| grp_cpu | input | 8 | Originating processor index per group |
| grp_indep | input | 8 | Per-group flag: event is processor-ID independent |
| grp_sub | input | 16 | Subunit index per group, 2 bits each |
| cnt_evt | output | 4 | Registered event pulse per counter |

## Verification
The bench targets group 7, whose code field overlaps the enable bit. A design that masked bit 63 out of that field would count code 0x01 while enabled. Two counters are placed on the same group, which catches a design that keeps a private code per counter. The filter is exercised with subunit index 3, with processor-independent events, and with each processor index separately. A swapped or missing acceptance term then shows up as a pulse on the wrong counter. Type values just past the last group, and the reserved cycle value with the enable and the filter cleared, check that group-index aliasing never leaks an event and that the cycle counter ignores every gate.

// File: rtl/evsel_pkg.sv
// Package: shared constants and types for the grouped event selection matrix.
// Assumes a 12-bit configuration address and a 64-bit data path.
package evsel_pkg;
    localparam int CFG_AW = 12;
    localparam int CFG_DW = 64;

    localparam logic [CFG_AW-1:0] ROWSEL_ADDR = 12'h410;
    localparam logic [CFG_AW-1:0] CTR_BASE    = 12'h500;

    localparam int TYPE_W = 8;
    localparam int FILT_W = 32;

    typedef logic [TYPE_W-1:0] ctr_type_t;
    typedef logic [FILT_W-1:0] ctr_filt_t;

    localparam ctr_type_t CYCLE_CODE = 8'hFE;

    // Origin and subunit filter layout: software writes fixed values, so positions matter.
    localparam int NUM_CPUS    = 2;
    localparam int NUM_SUBS    = 3;
    localparam int F_CPU_LSB   = 0;
    localparam int F_INDEP_BIT = 2;
    localparam int F_SUB_LSB   = 17;
    localparam int CPU_W       = $clog2(NUM_CPUS);
    localparam int SUB_W       = $clog2(NUM_SUBS + 1);

    localparam ctr_filt_t FILT_MASK = 32'h000E_0007;
endpackage

// File: rtl/evsel_cfg_regs.sv
// Module: configuration register file of the selection matrix.
// Holds the shared row-select register and, per counter, a type and a filter register.
// Assumes single-cycle writes and a combinational read port; unmapped accesses are inert.
module evsel_cfg_regs
    import evsel_pkg::*;
#(
    parameter int NUM_CNT = 4,
    parameter int RS_W    = 64
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            we,
    input  logic [CFG_AW-1:0]               addr,
    input  logic [CFG_DW-1:0]               wdata,
    output logic [CFG_DW-1:0]               rdata,
    output logic [RS_W-1:0]                 rowsel_q,
    output logic [NUM_CNT-1:0][TYPE_W-1:0]  type_q,
    output logic [NUM_CNT-1:0][FILT_W-1:0]  filt_q
);
    localparam int PAD_W = CFG_DW - RS_W;

    logic rowsel_hit;
    logic [NUM_CNT-1:0] type_hit;
    logic [NUM_CNT-1:0] filt_hit;

    assign rowsel_hit = (addr == ROWSEL_ADDR);

    // Row-select register: full-width write, software performs read-modify-write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rowsel_q <= '0;
        end else if (we && rowsel_hit) begin
            rowsel_q <= wdata[RS_W-1:0];
        end
    end

    for (genvar n = 0; n < NUM_CNT; n++) begin : g_ctr
        localparam logic [CFG_AW-1:0] T_ADDR = CTR_BASE + CFG_AW'(2 * n);
        localparam logic [CFG_AW-1:0] F_ADDR = CTR_BASE + CFG_AW'(2 * n + 1);

        assign type_hit[n] = (addr == T_ADDR);
        assign filt_hit[n] = (addr == F_ADDR);

        // Type register: names the group (or the cycle code) this counter follows.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                type_q[n] <= '0;
            end else if (we && type_hit[n]) begin
                type_q[n] <= wdata[TYPE_W-1:0];
            end
        end

        // Filter register: only the implemented accept bits are stored.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                filt_q[n] <= '0;
            end else if (we && filt_hit[n]) begin
                filt_q[n] <= wdata[FILT_W-1:0] & FILT_MASK;
            end
        end

        // R3: a write elsewhere never disturbs this counter's type register.
        p_type_keep_r3 : assert property (@(posedge clk) disable iff (!rst_n)
            (we && !type_hit[n]) |=> $stable(type_q[n]));
    end

    // Read mux: decoded address selects one register, zero otherwise.
    always_comb begin
        rdata = '0;
        if (rowsel_hit) begin
            rdata = {{PAD_W{1'b0}}, rowsel_q};
        end
        for (int n = 0; n < NUM_CNT; n++) begin
            if (type_hit[n]) begin
                rdata = {{(CFG_DW-TYPE_W){1'b0}}, type_q[n]};
            end
            if (filt_hit[n]) begin
                rdata = {{(CFG_DW-FILT_W){1'b0}}, filt_q[n]};
            end
        end
    end

    // R2 / R11: row-select only changes on a write to its own address.
    p_rowsel_keep_r2 : assert property (@(posedge clk) disable iff (!rst_n)
        (!(we && rowsel_hit)) |=> $stable(rowsel_q));
endmodule

// File: rtl/evsel_lane.sv
// Module: one counter's selection lane.
// Picks the event at [group][row-select code of that group], applies the global enable
// and the origin/subunit filter, and registers the result once for the counter bank.
// Assumes the number of codes per group is a power of two.
module evsel_lane
    import evsel_pkg::*;
#(
    parameter int NUM_GROUPS = 8,
    parameter int CODE_W     = 8
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic [NUM_GROUPS*CODE_W-1:0]      rowsel,
    input  ctr_type_t                         type_q,
    input  ctr_filt_t                         filt_q,
    input  logic [NUM_GROUPS*(1<<CODE_W)-1:0] evt_src,
    input  logic [NUM_GROUPS*CPU_W-1:0]       grp_cpu,
    input  logic [NUM_GROUPS-1:0]             grp_indep,
    input  logic [NUM_GROUPS*SUB_W-1:0]       grp_sub,
    output logic                              pulse
);
    localparam int RS_W   = NUM_GROUPS * CODE_W;
    localparam int EN_BIT = RS_W - 1;
    localparam int GRP_W  = $clog2(NUM_GROUPS);

    logic              grp_valid;
    logic [GRP_W-1:0]  grp;
    logic [CODE_W-1:0] code;
    logic              hit;
    logic [CPU_W-1:0]  cpu;
    logic              indep;
    logic [SUB_W-1:0]  sub;
    logic              sub_ok;
    logic              org_ok;
    logic              is_cycle;
    logic              sel;

    // Column and row lookup: group from the type register, row from the shared register.
    always_comb begin
        grp_valid = (32'(type_q) < NUM_GROUPS);
        grp       = type_q[GRP_W-1:0];
        code      = rowsel[grp*CODE_W +: CODE_W];
        hit       = evt_src[{grp, code}];
    end

    // Origin and subunit filtering on the selected group's attributes.
    always_comb begin
        cpu    = grp_cpu[grp*CPU_W +: CPU_W];
        indep  = grp_indep[grp];
        sub    = grp_sub[grp*SUB_W +: SUB_W];
        sub_ok = (32'(sub) < NUM_SUBS) && filt_q[F_SUB_LSB + 32'(sub)];
        org_ok = indep ? filt_q[F_INDEP_BIT] : filt_q[F_CPU_LSB + 32'(cpu)];
    end

    // Final gate: cycle code bypasses everything, grouped events need all checks.
    always_comb begin
        is_cycle = (type_q == CYCLE_CODE);
        sel      = is_cycle ||
                   (grp_valid && rowsel[EN_BIT] && hit && sub_ok && org_ok);
    end

    // Output register aligning the pulse with the counter bank.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pulse <= 1'b0;
        end else begin
            pulse <= sel;
        end
    end

    // R8: cycle code pulses on the following clock.
    p_cycle_pulse_r8 : assert property (@(posedge clk) disable iff (!rst_n)
        (type_q == CYCLE_CODE) |=> pulse);

    // R5: disabled row-select blocks every grouped event.
    p_disabled_quiet_r5 : assert property (@(posedge clk) disable iff (!rst_n)
        (!rowsel[EN_BIT] && type_q != CYCLE_CODE) |=> !pulse);

    // R7: out-of-range group types never pulse.
    p_bad_group_r7 : assert property (@(posedge clk) disable iff (!rst_n)
        (type_q >= NUM_GROUPS && type_q != CYCLE_CODE) |=> !pulse);

    // R9: with no subunit accepted nothing passes.
    p_no_subunit_r9 : assert property (@(posedge clk) disable iff (!rst_n)
        (filt_q[F_SUB_LSB +: NUM_SUBS] == '0 && type_q != CYCLE_CODE) |=> !pulse);

    // R10: with no origin accepted nothing passes.
    p_no_origin_r10 : assert property (@(posedge clk) disable iff (!rst_n)
        (filt_q[F_INDEP_BIT:F_CPU_LSB] == '0 && type_q != CYCLE_CODE) |=> !pulse);
endmodule

// File: rtl/evsel_matrix.sv
// Module: grouped event selection matrix, top level.
// A shared row-select register picks one code per group; each counter lane picks a group.
// Assumes NUM_GROUPS*CODE_W equals the 64-bit configuration data width.
module evsel_matrix
    import evsel_pkg::*;
#(
    parameter int NUM_GROUPS = 8,
    parameter int CODE_W     = 8,
    parameter int NUM_CNT    = 4
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              cfg_we,
    input  logic [CFG_AW-1:0]                 cfg_addr,
    input  logic [CFG_DW-1:0]                 cfg_wdata,
    output logic [CFG_DW-1:0]                 cfg_rdata,
    input  logic [NUM_GROUPS*(1<<CODE_W)-1:0] evt_src,
    input  logic [NUM_GROUPS*CPU_W-1:0]       grp_cpu,
    input  logic [NUM_GROUPS-1:0]             grp_indep,
    input  logic [NUM_GROUPS*SUB_W-1:0]       grp_sub,
    output logic [NUM_CNT-1:0]                cnt_evt
);
    localparam int RS_W = NUM_GROUPS * CODE_W;

    logic [RS_W-1:0]                rowsel_q;
    logic [NUM_CNT-1:0][TYPE_W-1:0] type_q;
    logic [NUM_CNT-1:0][FILT_W-1:0] filt_q;

    evsel_cfg_regs #(
        .NUM_CNT (NUM_CNT),
        .RS_W    (RS_W)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (cfg_we),
        .addr     (cfg_addr),
        .wdata    (cfg_wdata),
        .rdata    (cfg_rdata),
        .rowsel_q (rowsel_q),
        .type_q   (type_q),
        .filt_q   (filt_q)
    );

    for (genvar n = 0; n < NUM_CNT; n++) begin : g_lane
        evsel_lane #(
            .NUM_GROUPS (NUM_GROUPS),
            .CODE_W     (CODE_W)
        ) u_lane (
            .clk       (clk),
            .rst_n     (rst_n),
            .rowsel    (rowsel_q),
            .type_q    (type_q[n]),
            .filt_q    (filt_q[n]),
            .evt_src   (evt_src),
            .grp_cpu   (grp_cpu),
            .grp_indep (grp_indep),
            .grp_sub   (grp_sub),
            .pulse     (cnt_evt[n])
        );
    end

    // R1: the first clock after reset leaves all pulses low.
    p_reset_quiet_r1 : assert property (@(posedge clk)
        (!rst_n) |=> (cnt_evt == '0));
endmodule

// File: tb/evsel_matrix_test.sv
// Bench: scoreboard-driven check of the grouped event selection matrix.
module evsel_matrix_test;
    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_we = 1'b0;
    logic [11:0]   cfg_addr = '0;
    logic [63:0]   cfg_wdata = '0;
    logic [63:0]   cfg_rdata;
    logic [2047:0] evt_src = '0;
    logic [7:0]    grp_cpu = '0;
    logic [7:0]    grp_indep = '0;
    logic [15:0]   grp_sub = '0;
    logic [3:0]    cnt_evt;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    bit finished = 1'b0;

    typedef struct {
        int         due;
        logic [3:0] exp;
        string      tag;
    } item_t;
    item_t sb_q[$];

    evsel_matrix uut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .evt_src(evt_src),
        .grp_cpu(grp_cpu), .grp_indep(grp_indep), .grp_sub(grp_sub),
        .cnt_evt(cnt_evt)
    );

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // Monitor: compare the registered pulses with the expected item due this cycle.
    always @(negedge clk) begin
        if (sb_q.size() > 0 && sb_q[0].due == cyc) begin
            item_t it;
            it = sb_q.pop_front();
            total++;
            if (cnt_evt !== it.exp) begin
                bad++;
                $display("FAIL %s: cnt_evt=%b expected=%b", it.tag, cnt_evt, it.exp);
            end
        end
    end

    task automatic wr(input logic [11:0] a, input logic [63:0] d);
        @(negedge clk);
        evt_src   = '0;
        cfg_we    = 1'b1;
        cfg_addr  = a;
        cfg_wdata = d;
        @(negedge clk);
        cfg_we    = 1'b0;
    endtask

    task automatic rd_chk(input logic [11:0] a, input logic [63:0] exp, input string tag);
        @(negedge clk);
        cfg_addr = a;
        #1;
        total++;
        if (cfg_rdata !== exp) begin
            bad++;
            $display("FAIL %s: rdata=%h expected=%h", tag, cfg_rdata, exp);
        end
    endtask

    // Driver: apply one event pattern and queue the pulse vector expected next clock.
    task automatic drive(input int g, input int code, input bit cpu, input bit ind,
                         input logic [1:0] sub, input logic [3:0] exp, input string tag);
        item_t it;
        @(negedge clk);
        evt_src = '0;
        if (g >= 0) evt_src[g*256 + code] = 1'b1;
        grp_cpu   = {8{cpu}};
        grp_indep = {8{ind}};
        grp_sub   = {8{sub}};
        it.due = cyc + 1;
        it.exp = exp;
        it.tag = tag;
        sb_q.push_back(it);
    endtask

    localparam logic [63:0] FULL_FILT = 64'h000E_0007;
    localparam logic [63:0] RS_A = 64'h8100_0000_A500_3412;
    localparam logic [63:0] RS_B = 64'h8100_0000_A556_3412;

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog: expired expected=completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [63:0] rb;
        repeat (4) @(negedge clk);
        // R1: reset state
        total++;
        if (cnt_evt !== 4'b0) begin
            bad++;
            $display("FAIL R1: cnt_evt=%b expected=0000", cnt_evt);
        end
        rst_n = 1'b1;
        rd_chk(12'h410, 64'h0, "R1 rowsel reset");
        rd_chk(12'h500, 64'h0, "R1 type reset");
        rd_chk(12'h501, 64'h0, "R1 filter reset");
        drive(0, 0, 0, 0, 0, 4'b0000, "R1 quiet after reset");

        // R2: row-select readback and read-modify-write of group 2
        wr(12'h410, RS_A);
        rd_chk(12'h410, RS_A, "R2 rowsel readback");
        cfg_addr = 12'h410;
        #1 rb = cfg_rdata;
        rb[23:16] = 8'h56;
        wr(12'h410, rb);
        rd_chk(12'h410, RS_B, "R2 rowsel after RMW");

        // R3: type and filter registers
        wr(12'h500, 64'h0);
        wr(12'h502, 64'h1);
        wr(12'h504, 64'h3);
        wr(12'h506, 64'h0);
        wr(12'h501, 64'hFFFF_FFFF_FFFF_FFFF);
        rd_chk(12'h501, FULL_FILT, "R3 filter masked readback");
        rd_chk(12'h504, 64'h3, "R3 type readback");
        wr(12'h503, FULL_FILT);
        wr(12'h505, FULL_FILT);
        wr(12'h507, FULL_FILT);

        // R4 and R6: selection by group and row
        drive(0, 8'h12, 0, 0, 0, 4'b1001, "R4 R6 group0 code 0x12");
        drive(1, 8'h34, 0, 0, 0, 4'b0010, "R4 group1 code 0x34");
        drive(3, 8'hA5, 0, 0, 0, 4'b0100, "R4 group3 code 0xA5");
        drive(3, 8'hA4, 0, 0, 0, 4'b0000, "R4 group3 wrong code");
        drive(0, 8'h13, 0, 0, 0, 4'b0000, "R4 group0 wrong code");
        drive(2, 8'h56, 0, 0, 0, 4'b0000, "R4 unwatched group");
        // R4: back-to-back pattern for one-cycle alignment
        drive(0, 8'h12, 0, 0, 0, 4'b1001, "R4 stream on");
        drive(-1, 0, 0, 0, 0, 4'b0000, "R4 stream off");
        drive(1, 8'h34, 0, 0, 0, 4'b0010, "R4 stream next");

        // R12: group 7 shares its code MSB with the enable
        wr(12'h502, 64'h7);
        drive(7, 8'h81, 0, 0, 0, 4'b0010, "R12 group7 code 0x81");
        drive(7, 8'h01, 0, 0, 0, 4'b0000, "R12 group7 code 0x01 unreachable");

        // R5: enable cleared
        wr(12'h410, RS_B & ~(64'h1 << 63));
        drive(7, 8'h01, 0, 0, 0, 4'b0000, "R5 disabled group7");
        drive(0, 8'h12, 0, 0, 0, 4'b0000, "R5 disabled group0");

        // R8: cycle code ignores enable, filter and inputs
        wr(12'h504, 64'hFE);
        wr(12'h505, 64'h0);
        drive(-1, 0, 0, 0, 0, 4'b0100, "R8 cycle pulse 1");
        drive(-1, 0, 0, 0, 0, 4'b0100, "R8 cycle pulse 2");
        wr(12'h410, RS_B);
        wr(12'h505, FULL_FILT);

        // R7: out-of-range group types
        wr(12'h504, 64'h8);
        drive(0, 8'h12, 0, 0, 0, 4'b1001, "R7 type 8 silent");
        wr(12'h504, 64'hFF);
        drive(0, 8'h12, 0, 0, 0, 4'b1001, "R7 type 0xFF silent");
        wr(12'h504, 64'h0B);
        drive(3, 8'hA5, 0, 0, 0, 4'b0000, "R7 type 0x0B no alias");
        wr(12'h504, 64'h3);
        wr(12'h502, 64'h1);

        // R9: subunit filter
        wr(12'h501, 64'h000A_0007);
        drive(0, 8'h12, 0, 0, 2'd1, 4'b1000, "R9 subunit1 rejected by c0");
        drive(0, 8'h12, 0, 0, 2'd0, 4'b1001, "R9 subunit0 accepted");
        drive(0, 8'h12, 0, 0, 2'd3, 4'b0000, "R9 subunit3 never");

        // R10: origin filter
        wr(12'h501, 64'h000E_0006);
        wr(12'h507, 64'h000E_0003);
        drive(0, 8'h12, 0, 0, 0, 4'b1000, "R10 cpu0 rejected by c0");
        drive(0, 8'h12, 1, 0, 0, 4'b1001, "R10 cpu1 accepted");
        drive(0, 8'h12, 0, 1, 0, 4'b0001, "R10 indep only c0");
        wr(12'h501, 64'h0);
        drive(0, 8'h12, 0, 1, 0, 4'b0000, "R10 cleared filter silent");

        // R11: unmapped addresses
        wr(12'h411, 64'hFFFF_FFFF_FFFF_FFFF);
        wr(12'h508, 64'hFFFF_FFFF_FFFF_FFFF);
        rd_chk(12'h410, RS_B, "R11 rowsel untouched");
        rd_chk(12'h411, 64'h0, "R11 unmapped read 0x411");
        rd_chk(12'h508, 64'h0, "R11 unmapped read 0x508");
        rd_chk(12'h506, 64'h0, "R11 type c3 untouched");

        repeat (3) @(negedge clk);
        total++;
        if (sb_q.size() != 0) begin
            bad++;
            $display("FAIL scoreboard: pending=%0d expected=0", sb_q.size());
        end
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule